// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static Memory Controller

This block sits between a synchronous host and an external static memory that keeps its contents when the supply fails. The memory has no clock. It uses 21 address lines, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write strobe. The host issues one single-byte read or write at a time through a valid/ready request. The controller turns each request into the strobe, address and data-bus sequence the memory needs, and returns a one-cycle response that carries the read byte or an error flag.

All memory timing comes from counting clocks. The read access time, the width of the write strobe and the recovery gap after a write are parameters given in clock cycles. A power-fail input marks the supply as out of tolerance. While it is high, no new write strobe may start. A write strobe that is already active is cut short on the next clock, and the write is reported as failed. Reads still run during a power-fail.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and mem_we_n are high, req_ready is high and rsp_valid is low.
- R2: A read (req_write=0) drives mem_ce_n and mem_oe_n low with mem_we_n high and the request address on mem_addr. The byte the memory returns appears on rsp_rdata with rsp_err=0.
- R3: Read data is sampled at the clock edge ACC_CYC cycles after the edge that asserted chip select and output enable. rsp_valid is high in the cycle ACC_CYC+1 clocks after the accepting edge.
- R4: During a write (req_write=1), mem_oe_n stays high whenever mem_we_n is low. mem_we_n is low for exactly WP_CYC cycles (WP_CYC >= 2) unless a power-fail cuts it short.
- R5: mem_addr does not change while mem_ce_n stays low. Chip select is low for at least one cycle before mem_we_n falls. The address on the bus equals the request address.
- R6: The controller drives mem_dq only from the second cycle of the write strobe through the cycle after mem_we_n rises. The byte stored in memory equals req_wdata.
- R7: At least REC_CYC clock cycles pass between mem_we_n rising and the next fall of mem_ce_n. A write response arrives WP_CYC+REC_CYC+3 cycles after the accepting edge.
- R8: A write request accepted while pwr_fail is high produces no strobe and leaves the memory unchanged. It is answered one cycle after acceptance with rsp_err=1.
- R9: If pwr_fail is high at a clock edge, mem_we_n is high after that edge. A write whose strobe is interrupted this way responds with rsp_err=1.
- R10: Reads run normally while pwr_fail is high, with rsp_err=0.
- R11: Only one request is in flight. req_ready is low from the accepting edge until the response has been given, and mem_ce_n is high in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request is taken when valid and ready are both high at a clock edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| pwr_fail | input | 1 | Supply out of tolerance; blocks writes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write refused or aborted (valid with rsp_valid) |
| rsp_rdata | output | DATA_W | Byte from the last read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Memory data bus |

## Verification
The memory model in the bench returns the inverted byte until ACC_CYC cycles of chip select and output enable have passed. A controller that samples one cycle early therefore reads wrong data. The bench raises power-fail in the middle of a write strobe and also before a write request. A controller that ignores the input keeps the strobe low, writes over the stored byte or reports success. Back-to-back writes and reads that follow writes expose any cut in the recovery gap. A monitor also catches an address that changes while chip select is low. A data driver that turns on too late stores stale bytes, and the read-back catches them.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_WREC,
    ST_RACC,
    ST_DONE
  } nvs_state_e;
endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvs_iobuf.sv
module nvs_iobuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_nxt,
  input  logic              load_wdata,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  output logic              dq_drv,
  output logic [DATA_W-1:0] rdata,
  inout  wire  [DATA_W-1:0] dq
);
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_drv <= 1'b0;
      wd_q   <= '0;
      rdata  <= '0;
    end else begin
      dq_drv <= drive_nxt;
      if (load_wdata) wd_q  <= wdata;
      if (capture)    rdata <= dq;
    end
  end

  assign dq = dq_drv ? wd_q : {DATA_W{1'bz}};
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 25,
  parameter int WP_CYC  = 18,
  parameter int REC_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pwr_fail,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int MAX_AW = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_C  = (MAX_AW > REC_CYC) ? MAX_AW : REC_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  nvs_state_e       state, nxt;
  logic             accept, load, expired, err_set, drive_nxt, capture;
  logic [CNT_W-1:0] load_val;
  logic             dq_drv;

  assign accept = req_valid && req_ready;

  // Next-state logic; every timed state loads the counter on entry
  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    err_set  = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (!req_write) begin
          nxt      = ST_RACC;
          load     = 1'b1;
          load_val = CNT_W'(ACC_CYC - 1);
        end else if (pwr_fail) begin
          nxt     = ST_DONE;
          err_set = 1'b1;
        end else begin
          nxt = ST_WSETUP;
        end
      end
      ST_WSETUP: if (pwr_fail) begin
        nxt     = ST_DONE;
        err_set = 1'b1;
      end else begin
        nxt      = ST_WPULSE;
        load     = 1'b1;
        load_val = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: if (pwr_fail) begin
        nxt     = ST_WHOLD;
        err_set = 1'b1;
      end else if (expired) begin
        nxt = ST_WHOLD;
      end
      ST_WHOLD: begin
        nxt      = ST_WREC;
        load     = 1'b1;
        load_val = CNT_W'(REC_CYC - 1);
      end
      ST_WREC:  if (expired) nxt = ST_DONE;
      ST_RACC:  if (expired) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign drive_nxt = ((state == ST_WPULSE) && (nxt == ST_WPULSE)) || (nxt == ST_WHOLD);
  assign capture   = (state == ST_RACC) && expired;

  // Registered strobes and handshake, all derived from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      state     <= nxt;
      mem_ce_n  <= !(nxt inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC});
      mem_oe_n  <= (nxt != ST_RACC);
      mem_we_n  <= (nxt != ST_WPULSE);
      req_ready <= (nxt == ST_IDLE);
      rsp_valid <= (nxt == ST_DONE);
      if (accept)  mem_addr <= req_addr;
      if (err_set)     rsp_err <= 1'b1;
      else if (accept) rsp_err <= 1'b0;
    end
  end

  nvs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  nvs_iobuf #(.DATA_W(DATA_W)) u_iobuf (
    .clk        (clk),
    .rst        (rst),
    .drive_nxt  (drive_nxt),
    .load_wdata (accept),
    .wdata      (req_wdata),
    .capture    (capture),
    .dq_drv     (dq_drv),
    .rdata      (rsp_rdata),
    .dq         (mem_dq)
  );
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_fail,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dq_drv
);
  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_ce_before_we_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    dq_drv |-> (mem_oe_n && !mem_ce_n));

  p_pf_blocks_we_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> mem_we_n);

  p_ce_off_in_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (mem_ce_n && !req_ready));
endmodule

bind nvsram_ctrl nvs_chk #(.ADDR_W(ADDR_W)) u_nvs_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_fail  (pwr_fail),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .dq_drv    (dq_drv)
);

// File: tb/test_nvsram_ctrl.sv
`timescale 1ns/1ps
module test_nvsram_ctrl;
  localparam int AW = 21, DW = 8, ACC = 25, WP = 18, REC = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, pwr_fail = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, ce_n, oe_n, we_n;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] maddr;
  wire  [DW-1:0] dq;

  always #2 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .WP_CYC(WP), .REC_CYC(REC)) i_nvsram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pwr_fail(pwr_fail), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_addr(maddr), .mem_dq(dq));

  // Memory model: bytes are wrong until the access time has passed
  logic [DW-1:0] mem [0:4095];
  int acc_cnt = 0, wr_windows = 0;
  logic pend = 1'b0;
  logic [AW-1:0] pa, last_wa;
  logic [DW-1:0] pd;
  assign dq = (!ce_n && !oe_n && we_n) ?
              ((acc_cnt >= ACC-1) ? mem[maddr[11:0]] : ~mem[maddr[11:0]]) : {DW{1'bz}};

  always @(posedge clk) begin
    acc_cnt <= (ce_n || oe_n) ? 0 : acc_cnt + 1;
    if (!ce_n && !we_n) begin
      pend <= 1'b1; pa <= maddr; pd <= dq;
    end else if (pend) begin
      mem[pa[11:0]] <= pd; last_wa <= pa; wr_windows <= wr_windows + 1; pend <= 1'b0;
    end
  end

  // Bus monitors
  int v_addr = 0, v_oewr = 0, v_wp = 0, v_rec = 0, v_pf = 0, v_cersp = 0;
  int wl = 0, rc = 1000;
  bit pf_run = 0;
  logic p_ce = 1'b1, p_we = 1'b1, p_pf = 1'b0;
  logic [AW-1:0] p_addr = '0;
  always @(posedge clk) begin
    if (!rst) begin
      if (!ce_n && !p_ce && maddr !== p_addr) v_addr++;
      if (!we_n && !oe_n) v_oewr++;
      if (!we_n) begin
        if (p_pf) v_pf++;
        if (p_we) begin wl = 1; pf_run = 0; end else wl++;
      end
      if (pwr_fail) pf_run = 1;
      if (we_n && !p_we) begin
        if (!pf_run && wl != WP) v_wp++;
        rc = 0;
      end else if (rc < 1000) rc++;
      if (!ce_n && p_ce && rc < REC) v_rec++;
    end
    p_ce = ce_n; p_we = we_n; p_pf = pwr_fail; p_addr = maddr;
  end
  always @(negedge clk) if (!rst && rsp_valid && !ce_n) v_cersp++;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit wr, input bit pf);
    if (!wr) return ACC + 1;
    return pf ? 1 : WP + REC + 3;
  endfunction

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    output logic [DW-1:0] rd, output bit err, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready after accept", int'(req_ready), 0);
    lat = 1;
    while (!rsp_valid && lat < 1000) begin @(negedge clk); lat++; end
    rd = rsp_rdata; err = rsp_err;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  logic [DW-1:0] ref_m [0:4095];
  bit ref_v [0:4095];
  logic [AW-1:0] pool [0:15];

  initial begin
    logic [DW-1:0] rd; bit err; int lat, wbefore;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; ref_v[i] = 0; ref_m[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1", "strobes after reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(req_ready && !rsp_valid, "R1", "handshake after reset", {req_ready, rsp_valid}, 2'b10);

    // Directed write then read
    op(1, 21'h1ABCDE, 8'h5A, rd, err, lat);
    chk(lat == exp_lat(1, 0), "R7", "write latency", lat, exp_lat(1, 0));
    chk(!err, "R4", "write err", int'(err), 0);
    chk(last_wa == 21'h1ABCDE, "R5", "bus address", int'(last_wa), 21'h1ABCDE);
    ref_m[12'hCDE] = 8'h5A; ref_v[12'hCDE] = 1;
    op(0, 21'h1ABCDE, 8'h00, rd, err, lat);
    chk(lat == exp_lat(0, 0), "R3", "read latency", lat, exp_lat(0, 0));
    chk(rd == 8'h5A, "R6", "stored byte", int'(rd), 8'h5A);
    chk(rd == 8'h5A && !err, "R2", "read data", int'(rd), 8'h5A);

    // Write refused under power-fail, read still allowed
    pwr_fail = 1'b1;
    wbefore = wr_windows;
    op(1, 21'h1ABCDE, 8'hA5, rd, err, lat);
    chk(err, "R8", "refused err", int'(err), 1);
    chk(lat == exp_lat(1, 1), "R8", "refused latency", lat, exp_lat(1, 1));
    repeat (3) @(negedge clk);
    chk(wr_windows == wbefore, "R8", "write windows", wr_windows, wbefore);
    op(0, 21'h1ABCDE, 8'h00, rd, err, lat);
    chk(rd == 8'h5A && !err, "R10", "read under power-fail", int'(rd), 8'h5A);
    chk(lat == exp_lat(0, 0), "R10", "read latency under power-fail", lat, exp_lat(0, 0));
    pwr_fail = 1'b0;

    // Power-fail in the middle of a write strobe
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h0F0123; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!we_n, "R4", "strobe active", int'(we_n), 0);
    pwr_fail = 1'b1;
    @(negedge clk);
    chk(we_n, "R9", "strobe ends after power-fail", int'(we_n), 1);
    lat = 0;
    while (!rsp_valid && lat < 1000) begin @(negedge clk); lat++; end
    chk(rsp_err, "R9", "aborted write err", int'(rsp_err), 1);
    pwr_fail = 1'b0;
    ref_v[12'h123] = 0;

    // Address pool with distinct low bits
    for (int i = 0; i < 16; i++) begin
      logic [8:0] hi;
      hi = 9'($urandom_range(0, 511));
      pool[i] = {hi, 12'(i * 37 + 5)};
      op(1, pool[i], 8'(i * 11 + 1), rd, err, lat);
      ref_m[pool[i][11:0]] = 8'(i * 11 + 1); ref_v[pool[i][11:0]] = 1;
    end

    // Random mix
    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] a; logic [DW-1:0] d; bit wr, pf;
      a = pool[$urandom_range(0, 15)];
      d = 8'($urandom);
      wr = $urandom_range(0, 1) == 1;
      pf = $urandom_range(0, 7) == 0;
      pwr_fail = pf;
      op(wr, a, d, rd, err, lat);
      pwr_fail = 1'b0;
      chk(lat == exp_lat(wr, wr && pf), wr ? (pf ? "R8" : "R7") : "R3", "latency", lat, exp_lat(wr, wr && pf));
      chk(err == (wr && pf), pf ? (wr ? "R8" : "R10") : "R2", "err flag", int'(err), int'(wr && pf));
      if (wr && !pf) begin
        chk(last_wa == a, "R5", "bus address", int'(last_wa), int'(a));
        ref_m[a[11:0]] = d; ref_v[a[11:0]] = 1;
      end else if (!wr && ref_v[a[11:0]]) begin
        chk(rd == ref_m[a[11:0]], "R6", "read back", int'(rd), int'(ref_m[a[11:0]]));
      end
    end

    repeat (4) @(negedge clk);
    chk(v_addr == 0, "R5", "address moved under chip select", v_addr, 0);
    chk(v_oewr == 0, "R4", "output enable during write", v_oewr, 0);
    chk(v_wp == 0, "R4", "strobe width errors", v_wp, 0);
    chk(v_rec == 0, "R7", "recovery violations", v_rec, 0);
    chk(v_pf == 0, "R9", "strobe low after power-fail", v_pf, 0);
    chk(v_cersp == 0, "R11", "chip select in response cycle", v_cersp, 0);
    report();
  end
endmodule